// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one unsigned N-bit integer by another over several clock cycles. Quotient bits are produced one per cycle by the restoring method: a single working register of 2N bits holds the partial remainder in its upper half and collects the quotient bits in its lower half. There is no separate quotient register.

Each cycle the divisor is subtracted from the upper half as a trial. If the divisor fits, the difference replaces the upper half and a 1 enters as a quotient bit. If it does not fit, the upper half is kept and a 0 enters. The register is then shifted left. The register is shifted once when it is loaded, so the final partial remainder sits one place too far left. A right shift by one corrects it when the results are captured. The trial is N+1 bits wide, so the bit pushed out of the top of the upper half takes part in the fit decision.

A caller presents the operands and pulses `start` while the block is idle. Exactly N cycles later `done` pulses for one cycle, and the quotient and remainder are valid. They stay unchanged until the next operation completes. A zero divisor raises no trap, but it gives defined results.

Top module: `seqdiv_core`

## Requirements
- R1: On every completion, quotient × divisor + remainder equals the dividend that was captured at the accepted start.
- R2: When the captured divisor is nonzero, the remainder reported on completion is smaller than that divisor.
- R3: `done` rises exactly N clock edges after the edge that accepted `start`.
- R4: `done` is high for exactly one cycle per accepted operation.
- R5: `quotient` and `remainder` change only in a cycle in which `done` is high; otherwise they hold their values.
- R6: A zero divisor gives an all-ones quotient and a remainder equal to the dividend.
- R7: A `start` pulse, or a change on the operand inputs, while an operation is in progress or while `done` is high, is ignored. The running operation finishes with the operands it captured.
- R8: After reset, `done`, `quotient` and `remainder` are all zero.
- R9: With N = 4, dividing 7 by 2 gives quotient 3 and remainder 1.
- R10: Results are exact at the range limits. These include a dividend smaller than the divisor (quotient 0), a divisor of 1, all-ones operands, and divisors with the top bit set, where the bit shifted out of the upper half decides the fit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; accepted only when idle |
| dividend | input | N | Unsigned dividend, sampled on the accepting edge |
| divisor | input | N | Unsigned divisor, sampled on the accepting edge |
| done | output | 1 | One-cycle pulse marking valid results |
| quotient | output | N | Quotient of the last completed operation |
| remainder | output | N | Remainder of the last completed operation |

## Verification
The hardest case to reach from the ports is a trial in which the bit pushed out of the upper half is 1. There the N-bit view of the partial remainder looks smaller than the divisor, yet the divisor does fit. This case only appears when the divisor has its top bit set and the partial remainder is large. The stimulus reaches it with directed pairs such as an all-ones dividend over divisors just above half range, and over an all-ones divisor. Random operands are also biased toward large divisors. A second instance with N = 4 runs the small worked case 7 ÷ 2 and a full sweep of all 4-bit operand pairs.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seqdiv_state_e;

endpackage

// File: rtl/seqdiv_trial.sv
// Trial subtraction of the divisor from the (N+1)-bit partial remainder
// formed by the overflow bit and the upper half of the working register.
module seqdiv_trial #(
    parameter int N = 32
) (
    input  logic         ext_i,
    input  logic [N-1:0] hi_i,
    input  logic [N-1:0] dvs_i,
    output logic         fits_o,
    output logic [N-1:0] diff_o
);
    localparam int TW = N + 2;

    logic [TW-1:0] wide;

    always_comb begin
        wide   = {1'b0, ext_i, hi_i} - {2'b00, dvs_i};
        fits_o = ~wide[TW-1];
        diff_o = wide[N-1:0];
    end
endmodule

// File: rtl/seqdiv_fixup.sv
// Result extraction: the low half is the quotient; the upper half has been
// shifted one place too far and is shifted back right, pulling in the
// overflow bit.
module seqdiv_fixup #(
    parameter int N = 32
) (
    input  logic           ext_i,
    input  logic [2*N-1:0] acc_i,
    output logic [N-1:0]   quo_o,
    output logic [N-1:0]   rem_o
);
    always_comb begin
        quo_o = acc_i[N-1:0];
        rem_o = {ext_i, acc_i[2*N-1:N+1]};
    end
endmodule

// File: rtl/seqdiv_core.sv
module seqdiv_core #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] dividend,
    input  logic [N-1:0] divisor,
    output logic         done,
    output logic [N-1:0] quotient,
    output logic [N-1:0] remainder
);
    import seqdiv_pkg::*;

    localparam int CW = $clog2(N + 1);
    localparam int AW = 2 * N;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    typedef struct packed {
        seqdiv_state_e  st;
        logic [CW-1:0]  cnt;
        logic           ext;
        logic [AW-1:0]  acc;
        logic [N-1:0]   dvs;
        logic [N-1:0]   quo;
        logic [N-1:0]   rem;
        logic           done;
    } regs_t;

    regs_t r_q, r_d;

    logic         fits;
    logic [N-1:0] diff;
    logic [N-1:0] new_hi;
    logic         step_ext;
    logic [AW-1:0] step_acc;
    logic [N-1:0] fix_quo;
    logic [N-1:0] fix_rem;

    seqdiv_trial #(.N(N)) u_trial (
        .ext_i  (r_q.ext),
        .hi_i   (r_q.acc[AW-1:N]),
        .dvs_i  (r_q.dvs),
        .fits_o (fits),
        .diff_o (diff)
    );

    // restore on a failed trial, then shift left with the quotient bit
    always_comb begin
        new_hi               = fits ? diff : r_q.acc[AW-1:N];
        {step_ext, step_acc} = {new_hi, r_q.acc[N-1:0], fits};
    end

    seqdiv_fixup #(.N(N)) u_fix (
        .ext_i (step_ext),
        .acc_i (step_acc),
        .quo_o (fix_quo),
        .rem_o (fix_rem)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st  = ST_RUN;
                    r_d.cnt = '0;
                    r_d.ext = 1'b0;
                    // load with the initial left shift already applied
                    r_d.acc = {{(N-1){1'b0}}, dividend, 1'b0};
                    r_d.dvs = divisor;
                end
            end
            ST_RUN: begin
                r_d.ext = step_ext;
                r_d.acc = step_acc;
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) begin
                    r_d.st   = ST_DONE;
                    r_d.quo  = fix_quo;
                    r_d.rem  = fix_rem;
                    r_d.done = 1'b1;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, ext: 1'b0, acc: '0,
                     dvs: '0, quo: '0, rem: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done      = r_q.done;
    assign quotient  = r_q.quo;
    assign remainder = r_q.rem;

endmodule

// File: rtl/seqdiv_chk.sv
module seqdiv_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [N-1:0] dividend,
    input logic [N-1:0] divisor,
    input logic         done,
    input logic [N-1:0] quotient,
    input logic [N-1:0] remainder
);
    logic         busy_c;
    logic [31:0]  cyc_c;
    logic [N-1:0] op_a;
    logic [N-1:0] op_b;
    logic [2*N-1:0] recon;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_c <= 1'b0;
            cyc_c  <= '0;
            op_a   <= '0;
            op_b   <= '0;
        end else if (!busy_c && start) begin
            busy_c <= 1'b1;
            cyc_c  <= '0;
            op_a   <= dividend;
            op_b   <= divisor;
        end else if (busy_c) begin
            if (done) busy_c <= 1'b0;
            cyc_c <= cyc_c + 1;
        end
    end

    always_comb recon = {{N{1'b0}}, quotient} * {{N{1'b0}}, op_b}
                        + {{N{1'b0}}, remainder};

    a_r1_identity: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> recon == {{N{1'b0}}, op_a});

    a_r2_rem_below: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_b != '0) |-> remainder < op_b);

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_c && cyc_c == 32'(N)));

    a_r3_no_late: assert property (@(posedge clk) disable iff (!rst_n)
        busy_c |-> cyc_c <= 32'(N));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder)));

    a_r6_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_b == '0) |-> (quotient == '1 && remainder == op_a));

endmodule

bind seqdiv_core seqdiv_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/seqdiv_core_tb_top.sv
`timescale 1ns/1ps
module seqdiv_core_tb_top;
    localparam int W  = 32;
    localparam int WS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  a = '0, b = '0;
    logic          done;
    logic [W-1:0]  q, r;

    logic          start4 = 1'b0;
    logic [WS-1:0] a4 = '0, b4 = '0;
    logic          done4;
    logic [WS-1:0] q4, r4;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    seqdiv_core #(.N(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(a), .divisor(b),
        .done(done), .quotient(q), .remainder(r)
    );

    seqdiv_core #(.N(WS)) dut4_i (
        .clk(clk), .rst_n(rst_n), .start(start4), .dividend(a4), .divisor(b4),
        .done(done4), .quotient(q4), .remainder(r4)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Launch one operation on the wide instance; return the latency and
    // results. Inputs are driven on falling edges.
    task automatic launch(input logic [W-1:0] da, input logic [W-1:0] db,
                          output int lat, output logic [W-1:0] oq,
                          output logic [W-1:0] orr);
        @(negedge clk);
        a = da; b = db; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        oq = q; orr = r;
    endtask

    task automatic run_div(input logic [W-1:0] da, input logic [W-1:0] db,
                           input string req);
        int lat;
        logic [W-1:0] oq, orr, eq, er;
        launch(da, db, lat, oq, orr);
        if (db == '0) begin eq = '1; er = da; end
        else begin eq = da / db; er = da % db; end
        chk(lat == W, "R3", "latency", 64'(lat), 64'(W));
        chk(oq == eq, req, "quotient", 64'(oq), 64'(eq));
        chk(orr == er, req, "remainder", 64'(orr), 64'(er));
        chk(64'(oq) * 64'(db) + 64'(orr) == 64'(da), "R1", "identity",
            64'(oq) * 64'(db) + 64'(orr), 64'(da));
        if (db != '0) chk(orr < db, "R2", "rem below divisor", 64'(orr), 64'(db));
        @(negedge clk);
        chk(done == 1'b0, "R4", "done single cycle", 64'(done), 64'd0);
    endtask

    task automatic t_reset;
        chk(done == 1'b0, "R8", "done after reset", 64'(done), 64'd0);
        chk(q == '0, "R8", "quotient after reset", 64'(q), 64'd0);
        chk(r == '0, "R8", "remainder after reset", 64'(r), 64'd0);
    endtask

    task automatic run4(input logic [WS-1:0] da, input logic [WS-1:0] db,
                        input string req);
        int lat;
        logic [WS-1:0] eq, er;
        @(negedge clk);
        a4 = da; b4 = db; start4 = 1'b1;
        @(negedge clk);
        start4 = 1'b0;
        lat = 0;
        while (!done4 && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        if (db == '0) begin eq = '1; er = da; end
        else begin eq = da / db; er = da % db; end
        chk(lat == WS, "R3", "latency N=4", 64'(lat), 64'(WS));
        chk(q4 == eq, req, "quotient N=4", 64'(q4), 64'(eq));
        chk(r4 == er, req, "remainder N=4", 64'(r4), 64'(er));
        @(negedge clk);
    endtask

    task automatic t_small_example;   // R9
        run4(4'd7, 4'd2, "R9");
        chk(q4 == 4'd3, "R9", "7/2 quotient", 64'(q4), 64'd3);
        chk(r4 == 4'd1, "R9", "7/2 remainder", 64'(r4), 64'd1);
    endtask

    task automatic t_sweep4;          // R10 exhaustive at N=4
        for (int x = 0; x < 16; x++)
            for (int y = 1; y < 16; y++)
                run4(WS'(x), WS'(y), "R10");
    endtask

    task automatic t_limits;          // R10
        run_div(32'd5, 32'd9, "R10");
        run_div(32'hDEADBEEF, 32'd1, "R10");
        run_div(32'hFFFFFFFF, 32'hFFFFFFFF, "R10");
        run_div(32'hFFFFFFFF, 32'h80000001, "R10");
        run_div(32'hFFFFFFFE, 32'hC0000000, "R10");
        run_div(32'hFFFFFFFF, 32'h80000000, "R10");
        run_div(32'h0, 32'h12345, "R10");
        run_div(32'd100, 32'd7, "R1");
    endtask

    task automatic t_divzero;         // R6
        run_div(32'h89ABCDEF, 32'd0, "R6");
        run_div(32'h0, 32'd0, "R6");
        run4(4'd11, 4'd0, "R6");
    endtask

    task automatic t_busy_ignored;    // R7
        int lat;
        logic [W-1:0] oq, orr;
        @(negedge clk);
        a = 32'd1000; b = 32'd30; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        a = 32'd77; b = 32'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        a = 32'hFFFF; b = 32'd2;
        lat = 4;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        oq = q; orr = r;
        chk(lat == W, "R7", "latency kept", 64'(lat), 64'(W));
        chk(oq == 32'd33, "R7", "quotient of first op", 64'(oq), 64'd33);
        chk(orr == 32'd10, "R7", "remainder of first op", 64'(orr), 64'd10);
        // start while done is high is also ignored
        start = 1'b1; a = 32'd9; b = 32'd3;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 40, "R7", "start in done cycle ignored", 64'(lat), 64'd40);
        chk(q == 32'd33, "R7", "results unchanged", 64'(q), 64'd33);
    endtask

    task automatic t_hold;            // R5
        logic [W-1:0] hq, hr;
        run_div(32'd12345, 32'd67, "R1");
        hq = q; hr = r;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            a = $urandom; b = $urandom;
        end
        chk(q == hq, "R5", "quotient held", 64'(q), 64'(hq));
        chk(r == hr, "R5", "remainder held", 64'(r), 64'(hr));
    endtask

    task automatic t_random;          // R1 R2
        for (int i = 0; i < 150; i++) begin
            logic [W-1:0] da, db;
            da = $urandom;
            db = $urandom;
            if (i % 3 == 1) db = db | 32'h80000000;
            else if (i % 3 == 2) db = db >> (i % 31);
            if (db == '0) db = 32'd3;
            run_div(da, db, "R1");
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_small_example();
        t_limits();
        t_divzero();
        t_busy_ignored();
        t_hold();
        t_sweep4();
        t_random();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule